// File: doc/BRIEF.md
# SPI GPIO Expander Register Slave

This block is an SPI mode 0 slave that gives a host control of one 8-bit general-purpose pin port. The host reaches eleven 8-bit registers through the serial link. These registers set pin direction, input inversion, pull-up requests and the output latch, and they return the live pin levels. The pins are driven as a tri-state bus: a value output plus a per-pin output enable.

Every frame opens with a control byte. Its upper nibble is the fixed pattern 0100. Bits 3:1 carry a 3-bit device address and bit 0 selects read (1) or write (0). The next byte loads the register pointer. Each further byte is either written to the register the pointer selects or shifted out from it. After each data byte the pointer advances, unless the configuration register turns sequential stepping off. Several expanders can share one chip select. Each one compares the in-band address with its strap pins, but only once hardware addressing is enabled.

The serial inputs are oversampled by the system clock, so SCLK must run well below the clock rate.

Top module: `gpx_spi_expander`

## Requirements
- R1: After reset the direction register (index 0x00) reads 0xFF, every other register reads 0x00, pin_oe is 0x00 and spi_miso_oe is low.
- R2: A write frame (control byte 0x40 | addr<<1, then a pointer byte, then a data byte) stores the data byte in the register the pointer selects. Indices: 0x00 direction, 0x01 polarity, 0x02 interrupt enable, 0x03 compare value, 0x04 interrupt control, 0x05 configuration, 0x06 pull-up, 0x07 flag, 0x08 capture, 0x09 port, 0x0A latch.
- R3: A read frame (control byte bit 0 = 1) shifts out, MSB first, the selected register in the first byte after the pointer. While configuration bit 5 is 0, each further byte returns the next index, and index 0x0A is followed by 0x00.
- R4: While configuration bit 5 is 1, the pointer does not advance, so further bytes of a frame return the same register.
- R5: While configuration bit 3 is 0, control-byte bits 3:1 are ignored. While it is 1, a frame is accepted only when those bits equal strap_addr.
- R6: A frame whose control byte is rejected (upper nibble not 0100, or address mismatch under R5) changes no register and never asserts spi_miso_oe.
- R7: Raising spi_cs_n ends the frame. A partially received byte is discarded and writes nothing.
- R8: pin_oe is the bitwise inverse of the direction register (1 = input), pin_out is the latch register and pin_pullup is the pull-up register.
- R9: Reading index 0x09 returns pin_in XOR the polarity register. Writing index 0x09 updates the latch.
- R10: The flag (0x07) and capture (0x08) registers read 0x00, and writes to them are ignored.
- R11: The configuration register keeps only bits 6, 5, 3, 2 and 1. Bits 7, 4 and 0 read back as 0.
- R12: spi_miso_oe is high only during the data bytes of an accepted read frame, and low whenever spi_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 3 | Device address straps |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Values driven on output pins |
| pin_oe | output | 8 | Per-pin drive enable |
| pin_pullup | output | 8 | Per-pin pull-up request |

## Verification
The assertions check four things on every cycle. The direction register comes out of reset all ones. The pin outputs change only right after a register write. The pointer holds still after a data byte while sequential stepping is off. The MISO driver is released once chip select has been high long enough to pass the synchronizer. The bench scenarios cover the rest: that each register reads back correctly, that bursts wrap, that addresses are matched against the straps, that rejected and truncated frames leave the registers untouched, and that the port reads pin levels through the polarity inversion. Only end-to-end frames can show these.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef logic [7:0] byte_t;

    localparam int    NUM_REGS = 11;
    localparam byte_t LAST_REG = byte_t'(NUM_REGS - 1);

    // register indices
    localparam byte_t IX_DIR  = 8'h00;
    localparam byte_t IX_POL  = 8'h01;
    localparam byte_t IX_IEN  = 8'h02;
    localparam byte_t IX_DEFV = 8'h03;
    localparam byte_t IX_ICTL = 8'h04;
    localparam byte_t IX_CFG  = 8'h05;
    localparam byte_t IX_PULL = 8'h06;
    localparam byte_t IX_IFLG = 8'h07;
    localparam byte_t IX_ICAP = 8'h08;
    localparam byte_t IX_PORT = 8'h09;
    localparam byte_t IX_LAT  = 8'h0A;

    // configuration bit positions
    localparam int CFG_MIRROR   = 6;
    localparam int CFG_SEQ_OFF  = 5;
    localparam int CFG_ADDR_EN  = 3;
    localparam int CFG_OPEN_DRN = 2;
    localparam int CFG_INT_HIGH = 1;
    localparam byte_t CFG_WMASK = byte_t'((1 << CFG_MIRROR) | (1 << CFG_SEQ_OFF) |
                                          (1 << CFG_ADDR_EN) | (1 << CFG_OPEN_DRN) |
                                          (1 << CFG_INT_HIGH));

    localparam logic [3:0] CTRL_PREFIX = 4'b0100;

    typedef enum logic [1:0] {
        FR_CTRL,
        FR_PTR,
        FR_DATA,
        FR_DROP
    } frame_st_e;

    typedef struct packed {
        logic  wr_en;
        byte_t wr_data;
        byte_t ptr;
    } reg_req_t;

    function automatic byte_t next_ptr(input byte_t p);
        return (p >= LAST_REG) ? 8'h00 : p + 8'd1;
    endfunction

    function automatic logic ctrl_accept(input byte_t c, input logic addr_en,
                                         input logic [2:0] strap);
        return (c[7:4] == CTRL_PREFIX) && (!addr_en || (c[3:1] == strap));
    endfunction

endpackage

// File: rtl/gpx_spi_shift.sv
module gpx_spi_shift
    import gpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  mosi,
    input  byte_t tx_byte,
    output logic  cs_act,
    output logic  rx_valid,
    output byte_t rx_byte,
    output logic  miso
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, mosi_sr;
    logic       sclk_d;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    byte_t      tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
        end else begin
            sclk_sr[0] <= sclk;
            cs_sr[0]   <= cs_n;
            mosi_sr[0] <= mosi;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sclk_sr[i] <= sclk_sr[i-1];
                cs_sr[i]   <= cs_sr[i-1];
                mosi_sr[i] <= mosi_sr[i-1];
            end
        end
    end

    logic sclk_s, mosi_s, rise, fall;
    assign sclk_s = sclk_sr[LAST];
    assign mosi_s = mosi_sr[LAST];
    assign cs_act = ~cs_sr[LAST];
    assign rise   = sclk_s & ~sclk_d;
    assign fall   = ~sclk_s & sclk_d;
    assign miso   = tx_sh[7];

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else if (!cs_act) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh, mosi_s};
                end
            end
            if (fall) begin
                if (bit_cnt == 3'd0) tx_sh <= tx_byte;
                else                 tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/gpx_frame_ctrl.sv
module gpx_frame_ctrl
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_act,
    input  logic       rx_valid,
    input  byte_t      rx_byte,
    input  logic [2:0] strap,
    input  logic       addr_en,
    input  logic       seq_off,
    output reg_req_t   req,
    output logic       data_evt,
    output logic       miso_oe
);
    frame_st_e state;
    logic      is_read;
    byte_t     ptr;

    assign data_evt    = rx_valid && (state == FR_DATA);
    assign req.wr_en   = data_evt && !is_read;
    assign req.wr_data = rx_byte;
    assign req.ptr     = ptr;
    assign miso_oe     = cs_act && (state == FR_DATA) && is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FR_CTRL;
            is_read <= 1'b0;
            ptr     <= '0;
        end else if (!cs_act) begin
            state   <= FR_CTRL;
            is_read <= 1'b0;
        end else if (rx_valid) begin
            unique case (state)
                FR_CTRL: begin
                    if (ctrl_accept(rx_byte, addr_en, strap)) begin
                        state   <= FR_PTR;
                        is_read <= rx_byte[0];
                    end else begin
                        state <= FR_DROP;
                    end
                end
                FR_PTR: begin
                    ptr   <= rx_byte;
                    state <= FR_DATA;
                end
                FR_DATA: begin
                    if (!seq_off) ptr <= next_ptr(ptr);
                end
                default: state <= FR_DROP;
            endcase
        end
    end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
    import gpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req,
    input  byte_t    pin_in,
    output byte_t    rd_data,
    output byte_t    dir_q,
    output byte_t    lat_q,
    output byte_t    pull_q,
    output logic     seq_off,
    output logic     addr_en
);
    byte_t pol_q, ien_q, defv_q, ictl_q, cfg_q;
    byte_t pin_sr [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) pin_sr[i] <= '0;
        end else begin
            pin_sr[0] <= pin_in;
            for (int i = 1; i < SYNC_STAGES; i++) pin_sr[i] <= pin_sr[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= 8'hFF;
            pol_q  <= '0;
            ien_q  <= '0;
            defv_q <= '0;
            ictl_q <= '0;
            cfg_q  <= '0;
            pull_q <= '0;
            lat_q  <= '0;
        end else if (req.wr_en) begin
            case (req.ptr)
                IX_DIR:  dir_q  <= req.wr_data;
                IX_POL:  pol_q  <= req.wr_data;
                IX_IEN:  ien_q  <= req.wr_data;
                IX_DEFV: defv_q <= req.wr_data;
                IX_ICTL: ictl_q <= req.wr_data;
                IX_CFG:  cfg_q  <= req.wr_data & CFG_WMASK;
                IX_PULL: pull_q <= req.wr_data;
                IX_PORT: lat_q  <= req.wr_data;
                IX_LAT:  lat_q  <= req.wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (req.ptr)
            IX_DIR:  rd_data = dir_q;
            IX_POL:  rd_data = pol_q;
            IX_IEN:  rd_data = ien_q;
            IX_DEFV: rd_data = defv_q;
            IX_ICTL: rd_data = ictl_q;
            IX_CFG:  rd_data = cfg_q;
            IX_PULL: rd_data = pull_q;
            IX_PORT: rd_data = pin_sr[SYNC_STAGES-1] ^ pol_q;
            IX_LAT:  rd_data = lat_q;
            default: rd_data = '0;
        endcase
    end

    assign seq_off = cfg_q[CFG_SEQ_OFF];
    assign addr_en = cfg_q[CFG_ADDR_EN];
endmodule

// File: rtl/gpx_spi_expander.sv
module gpx_spi_expander
    import gpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] strap_addr,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic [7:0] pin_in,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe,
    output logic [7:0] pin_pullup
);
    logic     cs_act, rx_valid, data_evt, seq_off, addr_en;
    byte_t    rx_byte, rd_data, dir_q, lat_q, pull_q;
    reg_req_t req;

    gpx_spi_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_byte(rd_data), .cs_act(cs_act), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .miso(spi_miso)
    );

    gpx_frame_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cs_act(cs_act), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .strap(strap_addr), .addr_en(addr_en),
        .seq_off(seq_off), .req(req), .data_evt(data_evt), .miso_oe(spi_miso_oe)
    );

    gpx_regbank #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk(clk), .rst(rst), .req(req), .pin_in(pin_in), .rd_data(rd_data),
        .dir_q(dir_q), .lat_q(lat_q), .pull_q(pull_q),
        .seq_off(seq_off), .addr_en(addr_en)
    );

    assign pin_oe     = ~dir_q;
    assign pin_out    = lat_q;
    assign pin_pullup = pull_q;
endmodule

// File: rtl/gpx_spi_expander_chk.sv
module gpx_spi_expander_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       miso_oe,
    input logic [7:0] pin_oe,
    input logic [7:0] pin_out,
    input logic [7:0] dir_q,
    input logic       wr_en,
    input logic       data_evt,
    input logic       seq_off,
    input logic [7:0] ptr
);
    localparam int QUIET = SYNC_STAGES + 1;
    int unsigned cs_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cs_hi_cnt <= 0;
        else if (!spi_cs_n)        cs_hi_cnt <= 0;
        else if (cs_hi_cnt < QUIET) cs_hi_cnt <= cs_hi_cnt + 1;
    end

    assert_dir_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dir_q == 8'hFF);

    assert_pins_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(pin_oe) && $stable(pin_out)));

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $past(data_evt && seq_off) |-> ptr == $past(ptr));

    assert_miso_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (cs_hi_cnt >= QUIET) |-> !miso_oe);
endmodule

bind gpx_spi_expander gpx_spi_expander_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .miso_oe(spi_miso_oe),
    .pin_oe(pin_oe), .pin_out(pin_out), .dir_q(dir_q), .wr_en(req.wr_en),
    .data_evt(data_evt), .seq_off(seq_off), .ptr(req.ptr)
);

// File: tb/gpx_spi_expander_tb.sv
module gpx_spi_expander_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam logic [2:0] DEV = 3'b101;

    logic clk = 1'b0, rst = 1'b1;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [7:0] pin_in = 8'h00, pin_out, pin_oe, pin_pullup;
    logic [2:0] strap_addr = DEV;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpx_spi_expander u_dut (
        .clk(clk), .rst(rst), .strap_addr(strap_addr), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pullup(pin_pullup)
    );

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;
    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];
    logic oe_seen;
    logic [7:0] rd;

    // {write index, write data, read index, expected, tag}
    localparam logic [35:0] VEC [10] = '{
        {8'h00, 8'h3C, 8'h00, 8'h3C, 4'd2},
        {8'h01, 8'h0F, 8'h01, 8'h0F, 4'd2},
        {8'h02, 8'h81, 8'h02, 8'h81, 4'd2},
        {8'h03, 8'h42, 8'h03, 8'h42, 4'd2},
        {8'h06, 8'hA5, 8'h06, 8'hA5, 4'd2},
        {8'h0A, 8'h96, 8'h0A, 8'h96, 4'd2},
        {8'h09, 8'h5A, 8'h0A, 8'h5A, 4'd9},
        {8'h07, 8'hAA, 8'h07, 8'h00, 4'd10},
        {8'h08, 8'h55, 8'h08, 8'h00, 4'd10},
        {8'h05, 8'h91, 8'h05, 8'h00, 4'd11}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd9:    return "R9";
            4'd10:   return "R10";
            4'd11:   return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic frame(input int nbytes, input int extra_bits);
        spi_cs_n = 1'b0;
        oe_seen  = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < nbytes + 1; k++) begin
            for (int i = 7; i >= 0; i--) begin
                if (k == nbytes && (7 - i) >= extra_bits) break;
                spi_mosi = tx_buf[k][i];
                wait_clk(HALF);
                rx_buf[k][i] = spi_miso;
                if (spi_miso_oe) oe_seen = 1'b1;
                spi_sclk = 1'b1;
                wait_clk(HALF);
                spi_sclk = 1'b0;
            end
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(4*HALF);
    endtask

    task automatic wr(input logic [2:0] dev, input logic [7:0] a, input logic [7:0] d);
        tx_buf[0] = {4'b0100, dev, 1'b0};
        tx_buf[1] = a;
        tx_buf[2] = d;
        frame(3, 0);
    endtask

    task automatic rdreg(input logic [2:0] dev, input logic [7:0] a, output logic [7:0] d);
        tx_buf[0] = {4'b0100, dev, 1'b1};
        tx_buf[1] = a;
        tx_buf[2] = 8'h00;
        frame(3, 0);
        d = rx_buf[2];
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R12 oe idle", {7'd0, spi_miso_oe}, 8'h00);
        rdreg(DEV, 8'h00, rd); check("R1 dir", rd, 8'hFF);
        rdreg(DEV, 8'h0A, rd); check("R1 latch", rd, 8'h00);
        rdreg(DEV, 8'h05, rd); check("R1 cfg", rd, 8'h00);

        // table walk
        for (int v = 0; v < 10; v++) begin
            wr(DEV, VEC[v][35:28], VEC[v][27:20]);
            rdreg(DEV, VEC[v][19:12], rd);
            check(tag_name(VEC[v][3:0]), rd, VEC[v][11:4]);
        end

        // R8 pins
        wr(DEV, 8'h00, 8'hF0);
        wr(DEV, 8'h0A, 8'h3C);
        check("R8 pin_oe", pin_oe, 8'h0F);
        check("R8 pin_out", pin_out, 8'h3C);
        check("R8 pin_pullup", pin_pullup, 8'hA5);

        // R9 port read through polarity
        pin_in = 8'hA5;
        wr(DEV, 8'h01, 8'h0F);
        rdreg(DEV, 8'h09, rd);
        check("R9 port", rd, 8'hAA);
        check("R12 oe in read", {7'd0, oe_seen}, 8'h01);
        check("R12 oe after", {7'd0, spi_miso_oe}, 8'h00);

        // R3 sequential burst with wrap
        tx_buf[0] = {4'b0100, DEV, 1'b1}; tx_buf[1] = 8'h09;
        tx_buf[2] = 8'h00; tx_buf[3] = 8'h00; tx_buf[4] = 8'h00;
        frame(5, 0);
        check("R3 burst0", rx_buf[2], 8'hAA);
        check("R3 burst1", rx_buf[3], 8'h3C);
        check("R3 wrap", rx_buf[4], 8'hF0);

        // R4 sequential off
        wr(DEV, 8'h05, 8'h20);
        tx_buf[0] = {4'b0100, DEV, 1'b1}; tx_buf[1] = 8'h0A;
        frame(5, 0);
        check("R4 hold0", rx_buf[2], 8'h3C);
        check("R4 hold1", rx_buf[3], 8'h3C);
        check("R4 hold2", rx_buf[4], 8'h3C);
        wr(DEV, 8'h05, 8'h00);

        // R5 address ignored, then enforced
        wr(3'b010, 8'h06, 8'h11);
        rdreg(DEV, 8'h06, rd); check("R5 any addr", rd, 8'h11);
        wr(DEV, 8'h05, 8'h08);
        wr(3'b010, 8'h06, 8'h22);
        rdreg(DEV, 8'h06, rd); check("R5 mismatch", rd, 8'h11);
        rdreg(3'b010, 8'h06, rd);
        check("R6 oe mismatch", {7'd0, oe_seen}, 8'h00);
        wr(DEV, 8'h06, 8'h33);
        rdreg(DEV, 8'h06, rd); check("R5 match", rd, 8'h33);

        // R6 wrong prefix
        tx_buf[0] = 8'h60 | {4'd0, DEV, 1'b0}; tx_buf[1] = 8'h06; tx_buf[2] = 8'h44;
        frame(3, 0);
        rdreg(DEV, 8'h06, rd); check("R6 prefix", rd, 8'h33);
        tx_buf[0] = 8'h61 | {4'd0, DEV, 1'b0}; tx_buf[1] = 8'h06; tx_buf[2] = 8'h00;
        frame(3, 0);
        check("R6 oe prefix", {7'd0, oe_seen}, 8'h00);

        // R7 partial byte
        tx_buf[0] = {4'b0100, DEV, 1'b0}; tx_buf[1] = 8'h06; tx_buf[2] = 8'h77;
        frame(2, 5);
        rdreg(DEV, 8'h06, rd); check("R7 partial", rd, 8'h33);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule